// File: doc/BRIEF.md
# Back-Porch Digital Clamp

This block keeps the blanking level of a digitized composite video stream fixed. On every line it measures the back-porch level of the 8-bit converter samples inside a back-porch window. It then subtracts that level from each sample and adds a fixed target level that depends on the selected television standard: 0x3C for the 525-line standard and 0x40 for the 625-line standard. The corrected sample goes to an 8-bit output together with a matching valid strobe.

When the clamp is switched off, samples pass through with no change. Until the first complete measurement after reset, the level in use equals the target, so no correction is applied. The block runs on the pixel clock. The valid strobe qualifies every input sample, and the output follows the input by one clock.

Top module: `bp_clamp`

## Requirements
- R1: While reset is asserted, and after it until the first valid sample, `vid_o` is 0x00 and `vid_vld_o` is 0.
- R2: `vid_vld_o` equals `smp_vld_i` delayed by one clock. `vid_o` is updated only in the clock after a sample with `smp_vld_i` high and holds its value otherwise.
- R3: With `clamp_en_i` low, `vid_o` equals the `adc_data_i` value of the valid sample, unchanged.
- R4: With `clamp_en_i` high and no completed measurement since reset, `vid_o` equals the input sample (zero correction).
- R5: The measured level is floor(sum/16) of the first 16 valid samples taken while `bp_win_i` is high. Valid samples after the sixteenth in the same window are ignored. Once a measurement has completed, later lines keep using a measured level.
- R6: With the clamp on and a measured level L, `vid_o` = sample − L + T. T is 0x3C when `fmt_pal_i` = 0 and 0x40 when `fmt_pal_i` = 1.
- R7: The corrected value saturates: a negative result gives 0x00 and a result above 0xFF gives 0xFF.
- R8: A window that closes after fewer than 16 valid samples leaves the level unchanged.
- R9: A new level is taken over when `bp_win_i` falls. Samples presented while the window is open use the previous level. Samples presented after the window has been low for at least one clock use the new level.
- R10: Clocks with `smp_vld_i` low inside the window do not count toward the 16 samples and do not enter the sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Sample valid strobe |
| adc_data_i | input | 8 | Converter sample |
| bp_win_i | input | 1 | High during the back-porch measurement window |
| clamp_en_i | input | 1 | 1 = clamp applied, 0 = pass-through |
| fmt_pal_i | input | 1 | 0 = target 0x3C, 1 = target 0x40 |
| vid_o | output | 8 | Clamped video sample |
| vid_vld_o | output | 1 | Output valid, one clock after `smp_vld_i` |

## Verification
A corrupted sum or sample count shows up as a constant offset on every clamped sample from the first active sample after the window closes. That is two clocks after the window falls, so a single probe sample per line catches it. A level that is committed at the wrong time shows as samples inside the window that are already corrected by the new level. An out-of-range saturation path shows as wrapped values only at the extreme codes, so the tests drive samples near 0x00 and 0xFF against both a low and a high measured level.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic {
    FMT_NTSC = 1'b0,
    FMT_PAL  = 1'b1
  } fmt_e;
endpackage

// File: rtl/bpc_level_meas.sv
module bpc_level_meas #(
  parameter int DATA_W   = 8,
  parameter int AVG_LOG2 = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              win_i,
  output logic [DATA_W-1:0] level_o,
  output logic              level_ok_o
);
  localparam int NSMP  = 1 << AVG_LOG2;
  localparam int ACC_W = DATA_W + AVG_LOG2;
  localparam int CNT_W = AVG_LOG2 + 1;

  logic              win_q;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] level_q, level_d;
  logic              ok_q, ok_d;
  logic              take, full, closing;

  assign full    = (cnt_q == CNT_W'(NSMP));
  assign take    = smp_vld_i && win_i && !full;
  assign closing = win_q && !win_i;

  always_comb begin
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    level_d = level_q;
    ok_d    = ok_q;
    if (!win_i) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (take) begin
      acc_d = acc_q + ACC_W'(data_i);
      cnt_d = cnt_q + 1'b1;
    end
    if (closing && full) begin
      level_d = acc_q[ACC_W-1:AVG_LOG2];
      ok_d    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= 1'b0;
      acc_q   <= '0;
      cnt_q   <= '0;
      level_q <= '0;
      ok_q    <= 1'b0;
    end else begin
      win_q   <= win_i;
      acc_q   <= acc_d;
      cnt_q   <= cnt_d;
      level_q <= level_d;
      ok_q    <= ok_d;
    end
  end

  assign level_o    = level_q;
  assign level_ok_o = ok_q;
endmodule

// File: rtl/bpc_offset_alu.sv
module bpc_offset_alu
  import bpc_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] NTSC_LVL = 8'h3C,
  parameter logic [DATA_W-1:0] PAL_LVL  = 8'h40
) (
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] level_i,
  input  logic              level_ok_i,
  input  logic              en_i,
  input  fmt_e              fmt_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int EXT_W = DATA_W + 2;

  logic [DATA_W-1:0]       tgt, lvl_used;
  logic signed [EXT_W-1:0] sum_s;
  logic signed [EXT_W-1:0] max_s;

  assign tgt      = (fmt_i == FMT_PAL) ? PAL_LVL : NTSC_LVL;
  assign lvl_used = level_ok_i ? level_i : tgt;
  assign max_s    = $signed({2'b00, {DATA_W{1'b1}}});

  always_comb begin
    sum_s = $signed({2'b00, sample_i}) - $signed({2'b00, lvl_used})
          + $signed({2'b00, tgt});
    if (!en_i) begin
      result_o = sample_i;
    end else if (sum_s < 0) begin
      result_o = '0;
    end else if (sum_s > max_s) begin
      result_o = '1;
    end else begin
      result_o = sum_s[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/bp_clamp.sv
module bp_clamp
  import bpc_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                AVG_LOG2 = 4,
  parameter logic [DATA_W-1:0] NTSC_LVL = 8'h3C,
  parameter logic [DATA_W-1:0] PAL_LVL  = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [DATA_W-1:0] adc_data_i,
  input  logic              bp_win_i,
  input  logic              clamp_en_i,
  input  logic              fmt_pal_i,
  output logic [DATA_W-1:0] vid_o,
  output logic              vid_vld_o
);
  logic [DATA_W-1:0] level_q;
  logic              level_ok;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] vid_q, vid_d;
  logic              vld_q;
  fmt_e              fmt;

  assign fmt = fmt_e'(fmt_pal_i);

  bpc_level_meas #(
    .DATA_W  (DATA_W),
    .AVG_LOG2(AVG_LOG2)
  ) u_meas (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_vld_i (smp_vld_i),
    .data_i    (adc_data_i),
    .win_i     (bp_win_i),
    .level_o   (level_q),
    .level_ok_o(level_ok)
  );

  bpc_offset_alu #(
    .DATA_W  (DATA_W),
    .NTSC_LVL(NTSC_LVL),
    .PAL_LVL (PAL_LVL)
  ) u_alu (
    .sample_i  (adc_data_i),
    .level_i   (level_q),
    .level_ok_i(level_ok),
    .en_i      (clamp_en_i),
    .fmt_i     (fmt),
    .result_o  (alu_res)
  );

  assign vid_d = smp_vld_i ? alu_res : vid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vid_q <= vid_d;
      vld_q <= smp_vld_i;
    end
  end

  assign vid_o     = vid_q;
  assign vid_vld_o = vld_q;
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_vld_i,
  input logic [DATA_W-1:0] adc_data_i,
  input logic              bp_win_i,
  input logic              clamp_en_i,
  input logic [DATA_W-1:0] vid_o,
  input logic              vid_vld_o,
  input logic [DATA_W-1:0] level_q,
  input logic              level_ok
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_vld_delay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0) |-> (vid_vld_o == $past(smp_vld_i)));

  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q != 2'd0) && !$past(smp_vld_i)) |-> (vid_o == $past(vid_o)));

  p_bypass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q != 2'd0) && $past(smp_vld_i && !clamp_en_i))
      |-> (vid_o == $past(adc_data_i)));

  p_zero_corr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q != 2'd0) && $past(smp_vld_i && clamp_en_i && !level_ok))
      |-> (vid_o == $past(adc_data_i)));

  p_ok_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q != 2'd0) && $past(level_ok)) |-> level_ok);

  p_commit_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q >= 2'd2) && !$stable(level_q))
      |-> ($past(bp_win_i, 2) && !$past(bp_win_i)));
endmodule

bind bp_clamp bpc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .smp_vld_i (smp_vld_i),
  .adc_data_i(adc_data_i),
  .bp_win_i  (bp_win_i),
  .clamp_en_i(clamp_en_i),
  .vid_o     (vid_o),
  .vid_vld_o (vid_vld_o),
  .level_q   (level_q),
  .level_ok  (level_ok)
);

// File: tb/bp_clamp_tb.sv
module bp_clamp_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       vld, win, en, pal;
  logic [7:0] data;
  logic [7:0] vid;
  logic       vid_vld;

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0] m_lvl;
  bit         m_ok;

  always #4 clk = ~clk;

  bp_clamp u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .smp_vld_i (vld),
    .adc_data_i(data),
    .bp_win_i  (win),
    .clamp_en_i(en),
    .fmt_pal_i (pal),
    .vid_o     (vid),
    .vid_vld_o (vid_vld)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] d);
    int tgt, lv, v;
    if (!en) return d;
    tgt = pal ? 'h40 : 'h3C;
    lv  = m_ok ? int'(m_lvl) : tgt;
    v   = int'(d) - lv + tgt;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return 8'(v);
  endfunction

  // one valid sample, result check, then an idle clock with a hold check
  task automatic send(input logic [7:0] d, input string req);
    logic [7:0] e;
    e = model(d);
    @(negedge clk); vld = 1'b1; data = d;
    @(negedge clk); vld = 1'b0; data = ~d;
    chk("R2", int'(vid_vld), 1);
    chk(req, int'(vid), int'(e));
    @(negedge clk);
    chk("R2", int'(vid_vld), 0);
    chk("R2", int'(vid), int'(e));
  endtask

  // back-porch window: n counted samples, extra 0xFF samples, optional gaps
  task automatic window(input logic [7:0] base, input int n, input int extra,
                        input bit gaps);
    logic [7:0] d;
    @(negedge clk); win = 1'b1;
    for (int i = 0; i < n; i++) begin
      d = base + 8'(i & 3);
      vld = 1'b1; data = d;
      @(negedge clk);
      chk("R9", int'(vid), int'(model(d)));
      vld = 1'b0;
      if (gaps) begin
        data = 8'h00;
        @(negedge clk);
      end
    end
    for (int i = 0; i < extra; i++) begin
      vld = 1'b1; data = 8'hFF;
      @(negedge clk);
      chk("R9", int'(vid), int'(model(8'hFF)));
    end
    vld = 1'b0; win = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (n >= 16) begin
      m_lvl = base + 8'd1;
      m_ok  = 1'b1;
    end
  endtask

  task automatic t_reset;
    chk("R1", int'(vid), 0);
    chk("R1", int'(vid_vld), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1", int'(vid), 0);
    chk("R1", int'(vid_vld), 0);
  endtask

  task automatic t_bypass;
    en = 1'b0;
    send(8'h10, "R3");
    send(8'h80, "R3");
    send(8'hFF, "R3");
    send(8'h00, "R3");
  endtask

  task automatic t_no_meas;
    en = 1'b1; pal = 1'b0;
    send(8'h25, "R4");
    send(8'hC0, "R4");
    pal = 1'b1;
    send(8'h05, "R4");
    send(8'hFE, "R4");
  endtask

  task automatic t_measure;
    pal = 1'b0;
    window(8'h50, 16, 0, 1'b0);
    send(8'h60, "R5");
    chk("R6", int'(vid), 'h4B);
    pal = 1'b1;
    send(8'h60, "R6");
    chk("R6", int'(vid), 'h4F);
    pal = 1'b0;
  endtask

  task automatic t_saturate;
    send(8'h00, "R7");
    chk("R7", int'(vid), 0);
    pal = 1'b1;
    window(8'h10, 16, 0, 1'b0);
    send(8'hF0, "R7");
    chk("R7", int'(vid), 'hFF);
    send(8'hC0, "R6");
    pal = 1'b0;
  endtask

  task automatic t_short;
    window(8'h90, 10, 0, 1'b0);
    send(8'h40, "R8");
    chk("R8", int'(vid), 'h6B);
  endtask

  task automatic t_extra;
    window(8'h20, 16, 6, 1'b0);
    send(8'h40, "R5");
    chk("R5", int'(vid), 'h5B);
  endtask

  task automatic t_gaps;
    window(8'h30, 16, 0, 1'b1);
    send(8'h50, "R10");
    chk("R10", int'(vid), 'h5B);
  endtask

  task automatic t_bypass_after;
    en = 1'b0;
    send(8'h33, "R3");
    en = 1'b1;
    send(8'h33, "R6");
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; vld = 1'b0; win = 1'b0; en = 1'b0; pal = 1'b0;
    data = 8'h00; m_lvl = 8'h00; m_ok = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_bypass();
    t_no_meas();
    t_measure();
    t_saturate();
    t_short();
    t_extra();
    t_gaps();
    t_bypass_after();
    summary();
  end
endmodule